// File: doc/BRIEF.md
# Power-Gated Domain On/Off Sequencer

This block is a hardware sequencer that switches a single power-gated logic region on or off in a fixed, safe order. It drives the region's control lines: two switch enables that are brought up one after the other, output isolation, an active-low reset, a clock-disable line, a 4-bit SRAM power-down field, and a request to an external bus-protection unit. It follows two power-status acknowledges, per-bank SRAM power-down acknowledges and the bus-protection acknowledge. Every wait on an acknowledge is bounded by a programmable cycle budget.

Software drives the sequencer through a small register port. A write to the command register asks for power-up or power-down. Software then polls the status register for the busy, powered-on and error flags, which it reads together with a state code. A second register holds the timeout budget. Two parameters set the number of SRAM acknowledge bits that are checked (0 to 4) and whether the bus-protection handshake is used at all.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset, dom_ctl reads 0xF12 (reset asserted, isolation on, both enables low, clock disabled, SRAM field all ones), bus_prot_req is 1 when bus protection is enabled, and the status register reads 0.
- R2: The dom_ctl bits are fixed: bit 0 is the active-low reset, bit 1 isolation, bit 2 the first switch enable, bit 3 the second switch enable, bit 4 clock disable, bits 11:8 SRAM power-down, and bits 7:5 are always 0.
- R3: Power-up sets the first enable when the request is accepted and sets the second enable one cycle later. It then waits until both pwr_ack and pwr_ack2 are 1.
- R4: After the power acknowledges, power-up clears clock disable, then isolation, then raises the reset line, then clears the SRAM field. These are four steps on consecutive cycles in that order.
- R5: Power-up releases bus protection only once every configured SRAM acknowledge bit reads 0. With SRAM_ACK_W = 0 the SRAM acknowledges are never looked at.
- R6: Bus protection is released as the final power-up step. On power-down it is requested in the accept cycle, and the SRAM field is set only after bus_ack reads 1.
- R7: Once every configured SRAM acknowledge bit reads 1, power-down raises isolation. It then drops reset, sets clock disable, clears the first enable and clears the second enable, one step per cycle in that order.
- R8: Power-down reports completion (busy low, on flag low) only after both power acknowledges read 0.
- R9: If any wait lasts for the timeout budget, the sequence stops with the remaining steps not done, the error flag is set and busy falls. The next accepted request clears the error flag.
- R10: Register address 1 holds the 16-bit timeout budget in cycles. It resets to 1000 and reads back what was written.
- R11: Register address 0 takes commands on a write (bit 0 asks for power-up, bit 1 for power-down). On a read it returns busy in bit 0, the on flag in bit 1 and the error flag in bit 2. Busy is high from acceptance to completion, and commands written while busy are dropped.
- R12: A request for the state the region is already in changes no output and never raises busy.
- R13: With bus protection enabled, every wait also needs bus_ack equal to bus_prot_req. With BUS_PROT_EN = 0, bus_prot_req stays 0 and bus_ack is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| pwr_ack | input | 1 | First power-status acknowledge |
| pwr_ack2 | input | 1 | Second power-status acknowledge |
| sram_ack | input | 4 | SRAM power-down acknowledges, one per bank |
| bus_ack | input | 1 | Bus-protection acknowledge |
| dom_ctl | output | 12 | Region control word |
| bus_prot_req | output | 1 | Bus-protection request |

## Verification
The acknowledge models return each line after a short delay. Power-up and power-down are run back to back against them, with per-bit change times recorded so that a swapped or merged step shows up as a wrong order or a wrong cycle gap. Requests for the current state, and requests made while busy, are tried to show the difference between an ignored command and an accepted one. A held-low second power acknowledge under a short budget shows whether a timeout stops mid-sequence, and a retry shows whether it clears the error. A second instance, with no SRAM acknowledge bits and no bus protection, is fed SRAM acknowledges stuck at 1. This shows whether the SRAM wait is really skipped and whether the request line stays low.

// File: rtl/pds_pkg.sv
package pds_pkg;

    localparam int SRAM_BANKS = 4;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_ON_EN2    = 4'd1,
        ST_ON_WPWR   = 4'd2,
        ST_ON_ISO    = 4'd3,
        ST_ON_RST    = 4'd4,
        ST_ON_SRAM   = 4'd5,
        ST_ON_WSRAM  = 4'd6,
        ST_ON_WBUS   = 4'd7,
        ST_OFF_WBUS  = 4'd8,
        ST_OFF_WSRAM = 4'd9,
        ST_OFF_RST   = 4'd10,
        ST_OFF_CLK   = 4'd11,
        ST_OFF_EN1   = 4'd12,
        ST_OFF_EN2   = 4'd13,
        ST_OFF_WPWR  = 4'd14
    } seq_st_e;

    typedef struct packed {
        seq_st_e                 st;
        logic                    rst_b;
        logic                    iso;
        logic                    en1;
        logic                    en2;
        logic                    clk_dis;
        logic [SRAM_BANKS-1:0]   pdn;
        logic                    bus_req;
        logic                    dom_on;
        logic                    err;
    } seq_regs_t;

endpackage

// File: rtl/pds_timer.sv
module pds_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             waiting_i,
    input  logic             restart_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expire_o
);
    localparam logic [TMO_W-1:0] CNT_MAX = '1;

    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i || !waiting_i) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // expiry once the wait has lasted limit_i cycles
    assign expire_o = waiting_i &&
                      (({1'b0, cnt_q} + {{TMO_W{1'b0}}, 1'b1}) >= {1'b0, limit_i});

endmodule

// File: rtl/pds_regs.sv
module pds_regs #(
    parameter int DATA_W  = 16,
    parameter int TMO_W   = 16,
    parameter int TMO_RST = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy_i,
    input  logic              on_i,
    input  logic              err_i,
    input  logic [3:0]        st_i,
    output logic              cmd_on_o,
    output logic              cmd_off_o,
    output logic [TMO_W-1:0]  tmo_o
);
    localparam logic [1:0] ADDR_CMD = 2'd0;
    localparam logic [1:0] ADDR_TMO = 2'd1;
    localparam int         PAD_W    = DATA_W - 8;

    logic [TMO_W-1:0] tmo_d, tmo_q;

    always_comb begin
        tmo_d = tmo_q;
        if (reg_wr && reg_addr == ADDR_TMO) tmo_d = reg_wdata[TMO_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmo_q <= TMO_W'(TMO_RST);
        else        tmo_q <= tmo_d;
    end

    assign cmd_on_o  = reg_wr && reg_addr == ADDR_CMD && reg_wdata[0];
    assign cmd_off_o = reg_wr && reg_addr == ADDR_CMD && reg_wdata[1];
    assign tmo_o     = tmo_q;

    always_comb begin
        case (reg_addr)
            ADDR_CMD: reg_rdata = {{PAD_W{1'b0}}, st_i, 1'b0, err_i, on_i, busy_i};
            ADDR_TMO: reg_rdata = DATA_W'(tmo_q);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
    import pds_pkg::*;
#(
    parameter int SRAM_ACK_W  = 4,
    parameter bit BUS_PROT_EN = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_on_i,
    input  logic                  cmd_off_i,
    input  logic                  pwr_ack_i,
    input  logic                  pwr_ack2_i,
    input  logic [SRAM_BANKS-1:0] sram_ack_i,
    input  logic                  bus_ack_i,
    input  logic                  expire_i,
    output seq_regs_t             regs_o,
    output logic                  waiting_o,
    output logic                  restart_o
);
    localparam logic [SRAM_BANKS-1:0] ACK_MASK =
        SRAM_BANKS'((5'd1 << SRAM_ACK_W) - 5'd1);
    localparam logic [SRAM_BANKS-1:0] PDN_ALL = '1;

    seq_regs_t q, d;
    logic      bus_ok;
    logic [SRAM_BANKS-1:0] sram_seen;

    assign bus_ok    = !BUS_PROT_EN || (bus_ack_i == q.bus_req);
    assign sram_seen = sram_ack_i & ACK_MASK;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (cmd_on_i && !q.dom_on) begin
                    d.en1 = 1'b1;
                    d.err = 1'b0;
                    d.st  = ST_ON_EN2;
                end else if (cmd_off_i && q.dom_on) begin
                    d.bus_req = BUS_PROT_EN;
                    d.err     = 1'b0;
                    d.st      = ST_OFF_WBUS;
                end
            end
            ST_ON_EN2: begin
                d.en2 = 1'b1;
                d.st  = ST_ON_WPWR;
            end
            ST_ON_WPWR: begin
                if (pwr_ack_i && pwr_ack2_i && bus_ok) begin
                    d.clk_dis = 1'b0;
                    d.st      = ST_ON_ISO;
                end else if (expire_i) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            ST_ON_ISO: begin
                d.iso = 1'b0;
                d.st  = ST_ON_RST;
            end
            ST_ON_RST: begin
                d.rst_b = 1'b1;
                d.st    = ST_ON_SRAM;
            end
            ST_ON_SRAM: begin
                d.pdn = '0;
                d.st  = ST_ON_WSRAM;
            end
            ST_ON_WSRAM: begin
                if (sram_seen == '0 && bus_ok) begin
                    d.bus_req = 1'b0;
                    d.st      = ST_ON_WBUS;
                end else if (expire_i) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            ST_ON_WBUS: begin
                if (bus_ok) begin
                    d.dom_on = 1'b1;
                    d.st     = ST_IDLE;
                end else if (expire_i) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            ST_OFF_WBUS: begin
                if (bus_ok) begin
                    d.pdn = PDN_ALL;
                    d.st  = ST_OFF_WSRAM;
                end else if (expire_i) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            ST_OFF_WSRAM: begin
                if (sram_seen == ACK_MASK && bus_ok) begin
                    d.iso = 1'b1;
                    d.st  = ST_OFF_RST;
                end else if (expire_i) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            ST_OFF_RST: begin
                d.rst_b = 1'b0;
                d.st    = ST_OFF_CLK;
            end
            ST_OFF_CLK: begin
                d.clk_dis = 1'b1;
                d.st      = ST_OFF_EN1;
            end
            ST_OFF_EN1: begin
                d.en1 = 1'b0;
                d.st  = ST_OFF_EN2;
            end
            ST_OFF_EN2: begin
                d.en2 = 1'b0;
                d.st  = ST_OFF_WPWR;
            end
            ST_OFF_WPWR: begin
                if (!pwr_ack_i && !pwr_ack2_i && bus_ok) begin
                    d.dom_on = 1'b0;
                    d.st     = ST_IDLE;
                end else if (expire_i) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.rst_b   <= 1'b0;
            q.iso     <= 1'b1;
            q.en1     <= 1'b0;
            q.en2     <= 1'b0;
            q.clk_dis <= 1'b1;
            q.pdn     <= PDN_ALL;
            q.bus_req <= BUS_PROT_EN;
            q.dom_on  <= 1'b0;
            q.err     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.st)
            ST_ON_WPWR, ST_ON_WSRAM, ST_ON_WBUS,
            ST_OFF_WBUS, ST_OFF_WSRAM, ST_OFF_WPWR: waiting_o = 1'b1;
            default:                                waiting_o = 1'b0;
        endcase
    end

    assign restart_o = (d.st != q.st);
    assign regs_o    = q;

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
    import pds_pkg::*;
#(
    parameter int SRAM_ACK_W  = 4,
    parameter bit BUS_PROT_EN = 1'b1,
    parameter int TMO_W       = 16,
    parameter int TMO_RST     = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        pwr_ack,
    input  logic        pwr_ack2,
    input  logic [3:0]  sram_ack,
    input  logic        bus_ack,
    output logic [11:0] dom_ctl,
    output logic        bus_prot_req
);
    seq_regs_t        regs_w;
    logic             cmd_on_w, cmd_off_w, expire_w, waiting_w, restart_w;
    logic             busy_w, err_w;
    logic [TMO_W-1:0] tmo_w;

    assign busy_w = (regs_w.st != ST_IDLE);
    assign err_w  = regs_w.err;

    pds_regs #(.DATA_W(16), .TMO_W(TMO_W), .TMO_RST(TMO_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy_i    (busy_w),
        .on_i      (regs_w.dom_on),
        .err_i     (err_w),
        .st_i      (regs_w.st),
        .cmd_on_o  (cmd_on_w),
        .cmd_off_o (cmd_off_w),
        .tmo_o     (tmo_w)
    );

    pds_fsm #(.SRAM_ACK_W(SRAM_ACK_W), .BUS_PROT_EN(BUS_PROT_EN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_on_i   (cmd_on_w),
        .cmd_off_i  (cmd_off_w),
        .pwr_ack_i  (pwr_ack),
        .pwr_ack2_i (pwr_ack2),
        .sram_ack_i (sram_ack),
        .bus_ack_i  (bus_ack),
        .expire_i   (expire_w),
        .regs_o     (regs_w),
        .waiting_o  (waiting_w),
        .restart_o  (restart_w)
    );

    pds_timer #(.TMO_W(TMO_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .waiting_i (waiting_w),
        .restart_i (restart_w),
        .limit_i   (tmo_w),
        .expire_o  (expire_w)
    );

    assign dom_ctl      = {regs_w.pdn, 3'b000, regs_w.clk_dis, regs_w.en2,
                           regs_w.en1, regs_w.iso, regs_w.rst_b};
    assign bus_prot_req = regs_w.bus_req;

endmodule

// File: rtl/pds_chk.sv
module pds_chk #(
    parameter int SRAM_ACK_W = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] dom_ctl,
    input logic        bus_prot_req,
    input logic        busy,
    input logic        err,
    input logic        pwr_ack,
    input logic        pwr_ack2,
    input logic [3:0]  sram_ack
);
    localparam logic [3:0] MASK = 4'((5'd1 << SRAM_ACK_W) - 5'd1);

    assert_en2_after_en1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_ctl[3]) |-> $past(dom_ctl[2]));

    assert_clk_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_ctl[4]) |-> $past(pwr_ack && pwr_ack2));

    assert_iso_after_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_ctl[1]) |-> !dom_ctl[4]);

    assert_release_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_prot_req) |-> ($past((sram_ack & MASK) == 4'h0)
                                 && dom_ctl[0] && dom_ctl[11:8] == 4'h0));

    assert_iso_after_pdn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_ctl[1]) |-> dom_ctl[11:8] == 4'hF);

    assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);

    assert_change_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({dom_ctl, bus_prot_req}) |-> (busy || $past(busy)));

endmodule

bind pwr_dom_seq pds_chk #(.SRAM_ACK_W(SRAM_ACK_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dom_ctl      (dom_ctl),
    .bus_prot_req (bus_prot_req),
    .busy         (busy_w),
    .err          (err_w),
    .pwr_ack      (pwr_ack),
    .pwr_ack2     (pwr_ack2),
    .sram_ack     (sram_ack)
);

// File: tb/tb_pwr_dom_seq.sv
`timescale 1ns/1ps
module tb_pwr_dom_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata, np_rdata;
    logic        pwr_ack, pwr_ack2, bus_ack;
    logic [3:0]  sram_ack;
    logic [11:0] dom_ctl, np_ctl;
    logic        bus_prot_req, np_bus;
    logic        stuck = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_dom_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_ack(pwr_ack),
        .pwr_ack2(pwr_ack2), .sram_ack(sram_ack), .bus_ack(bus_ack),
        .dom_ctl(dom_ctl), .bus_prot_req(bus_prot_req));

    // variant: no SRAM acknowledge, no bus protection
    logic [2:0] np_p1, np_p2;
    pwr_dom_seq #(.SRAM_ACK_W(0), .BUS_PROT_EN(1'b0)) dut_np (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(np_rdata), .pwr_ack(np_p1[2]),
        .pwr_ack2(np_p2[2]), .sram_ack(4'hF), .bus_ack(1'b1),
        .dom_ctl(np_ctl), .bus_prot_req(np_bus));

    // delayed acknowledge models
    logic [2:0] p1_sh, p2_sh, bus_sh;
    logic [3:0] s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p1_sh <= '0; p2_sh <= '0; bus_sh <= '1;
            s1 <= 4'hF; s2 <= 4'hF; s3 <= 4'hF;
            np_p1 <= '0; np_p2 <= '0;
        end else begin
            p1_sh  <= {p1_sh[1:0], dom_ctl[2]};
            p2_sh  <= {p2_sh[1:0], dom_ctl[3]};
            bus_sh <= {bus_sh[1:0], bus_prot_req};
            s1 <= dom_ctl[11:8]; s2 <= s1; s3 <= s2;
            np_p1 <= {np_p1[1:0], np_ctl[2]};
            np_p2 <= {np_p2[1:0], np_ctl[3]};
        end
    end
    assign pwr_ack  = p1_sh[2];
    assign pwr_ack2 = p2_sh[2] & ~stuck;
    assign bus_ack  = bus_sh[2];
    assign sram_ack = s3;

    // change-time monitor
    int cyc = 0, chg = 0;
    int t_en1, t_en2, t_clk, t_iso, t_rst, t_pdn, t_bus, t_ack;
    logic [11:0] prev_ctl = 12'hF12;
    logic        prev_bus = 1'b1, prev_ack2 = 1'b0;
    logic [3:0]  sram_at_bus;
    bit          np_bus_seen = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (dom_ctl[2] != prev_ctl[2]) t_en1 = cyc;
            if (dom_ctl[3] != prev_ctl[3]) t_en2 = cyc;
            if (dom_ctl[4] != prev_ctl[4]) t_clk = cyc;
            if (dom_ctl[1] != prev_ctl[1]) t_iso = cyc;
            if (dom_ctl[0] != prev_ctl[0]) t_rst = cyc;
            if (dom_ctl[11:8] != prev_ctl[11:8]) t_pdn = cyc;
            if (bus_prot_req != prev_bus) begin
                t_bus = cyc; sram_at_bus = sram_ack;
            end
            if (pwr_ack2 && !prev_ack2) t_ack = cyc;
            if (dom_ctl != prev_ctl || bus_prot_req != prev_bus) chg++;
            if (np_bus) np_bus_seen = 1'b1;
        end
        prev_ctl = dom_ctl; prev_bus = bus_prot_req; prev_ack2 = pwr_ack2;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 16'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle(output logic [15:0] st);
        st = 16'h1;
        for (int k = 0; k < 400 && st[0]; k++) rd(2'd0, st);
    endtask

    // vector: [15:14] command, [13] expected on, [12] expected bus req, [11:0] expected ctl
    localparam logic [15:0] VEC [0:5] = '{
        {2'b10, 1'b0, 1'b1, 12'hF12},
        {2'b01, 1'b1, 1'b0, 12'h00D},
        {2'b01, 1'b1, 1'b0, 12'h00D},
        {2'b10, 1'b0, 1'b1, 12'hF12},
        {2'b01, 1'b1, 1'b0, 12'h00D},
        {2'b10, 1'b0, 1'b1, 12'hF12}
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [15:0] st, v;
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 reset state
        @(negedge clk);
        check(dom_ctl == 12'hF12, "R1 R2 reset ctl", dom_ctl, 12'hF12);
        check(bus_prot_req == 1'b1, "R1 reset bus req", bus_prot_req, 1);
        rd(2'd0, st);
        check(st == 16'h0, "R1 reset status", st, 0);
        rd(2'd1, v);
        check(v == 16'd1000, "R10 reset timeout", v, 1000);

        for (int i = 0; i < 6; i++) begin
            c0 = chg;
            wr(2'd0, {14'd0, VEC[i][15:14]});
            if (i == 1) begin
                // R11 busy visible and commands dropped while busy
                rd(2'd0, st);
                check(st[0] == 1'b1, "R11 busy after accept", st[0], 1);
                wr(2'd0, 16'h2);
            end
            wait_idle(st);
            check(st[1] == VEC[i][13] && st[2] == 1'b0, "R11 status after vector",
                  st[2:0], {VEC[i][13], 1'b0});
            check(dom_ctl == VEC[i][11:0], "R2 ctl after vector", dom_ctl, VEC[i][11:0]);
            check(bus_prot_req == VEC[i][12], "R6 bus req after vector", bus_prot_req, VEC[i][12]);
            if (i == 0 || i == 2)
                check(chg == c0, "R12 same-state request no change", chg - c0, 0);
            if (i == 1) begin
                check(t_en2 == t_en1 + 1, "R3 second enable one cycle later", t_en2 - t_en1, 1);
                check(t_clk > t_ack && t_ack > t_en2, "R3 wait for power ack", t_clk - t_ack, 1);
                check(t_iso == t_clk + 1 && t_rst == t_iso + 1 && t_pdn == t_rst + 1,
                      "R4 on steps consecutive", t_pdn - t_clk, 3);
                check(t_bus > t_pdn && sram_at_bus == 4'h0, "R5 release after SRAM ack",
                      sram_at_bus, 0);
                check(np_rdata[1] == 1'b1, "R5 empty mask skips SRAM wait", np_rdata[1], 1);
            end
            if (i == 3) begin
                check(t_pdn > t_bus + 2, "R6 SRAM after bus ack", t_pdn - t_bus, 3);
                check(t_iso > t_pdn && t_rst == t_iso + 1 && t_clk == t_rst + 1 &&
                      t_en1 == t_clk + 1 && t_en2 == t_en1 + 1, "R7 off order",
                      t_en2 - t_iso, 4);
                check(pwr_ack == 1'b0 && pwr_ack2 == 1'b0, "R8 off waits power ack low",
                      {pwr_ack, pwr_ack2}, 0);
            end
        end
        check(np_bus_seen == 1'b0, "R13 disabled protection keeps request low", np_bus_seen, 0);

        // R10 timeout register, R9 timeout
        wr(2'd1, 16'd20);
        rd(2'd1, v);
        check(v == 16'd20, "R10 timeout readback", v, 20);
        stuck = 1'b1;
        wr(2'd0, 16'h1);
        repeat (10) @(negedge clk);
        rd(2'd0, st);
        check(st[0] == 1'b1, "R9 still waiting before budget", st[0], 1);
        repeat (40) @(negedge clk);
        rd(2'd0, st);
        check(st[2:0] == 3'b100, "R9 error flag set, idle", st[2:0], 3'b100);
        check(dom_ctl == 12'hF1E, "R9 remaining steps skipped", dom_ctl, 12'hF1E);
        stuck = 1'b0;
        wr(2'd0, 16'h1);
        wait_idle(st);
        check(st[2:0] == 3'b010, "R9 retry clears error", st[2:0], 3'b010);
        check(dom_ctl == 12'h00D, "R13 retry completes with bus ack", dom_ctl, 12'h00D);

        finish_run();
    end
endmodule